// File: doc/BRIEF.md
# Hardware Breakpoint Match Unit

This unit watches the access stream of a processor core and compares every access against four programmable breakpoint addresses. Software programs a 32-bit control word that enables each breakpoint, chooses which access kind it reacts to and sets how many bytes it covers. It also programs one address register per breakpoint. Each cycle the core presents at most one access: its address, its size and a kind tag. One cycle later the unit reports which breakpoints matched and whether the event is a fault or a trap. Instruction-fetch matches are faults, taken before the instruction runs. Data and I/O matches are traps, taken after the instruction completes.

A sticky status word records every breakpoint that has hit and keeps it until software overwrites the word. The control word also carries a general-detect arm bit. While that bit is armed, any attempt by the core to touch a debug register raises a separate exception and sets a status flag. The arm bit clears itself whenever the unit raises any debug exception, so a debugger that takes over does not trip over its own register accesses.

Top module: `hwbp_unit`

## Requirements
- R1: After reset the control word, the status word and all event outputs (`hit_vec`, `hit_fault`, `hit_trap`, `gd_exc`) read 0.
- R2: The length field selects how many bytes a breakpoint covers: 00b is one byte, 01b is two bytes and 11b is four bytes. The stored address is aligned first, with bit 0 cleared for two bytes and bits 1:0 cleared for four. A breakpoint matches when any byte of the access (`acc_addr` up to `acc_addr + acc_nb_m1`) falls inside that aligned range.
- R3: A breakpoint whose length field is 10b never matches.
- R4: The type field selects the access kinds a breakpoint reacts to: 00b matches fetches only (`acc_kind` 00b), 01b matches data writes only (`acc_kind` 10b), 11b matches data reads (01b) and data writes (10b), and 10b matches I/O accesses (11b).
- R5: A breakpoint with type 00b and any length other than 00b never matches.
- R6: A breakpoint with type 10b never matches while `dbg_ext_en` is 0.
- R7: Breakpoint n has two enable bits, at control bits 2n and 2n+1. It can match only when at least one of them is 1. Its type field sits at control bits 17+4n:16+4n and its length field at 19+4n:18+4n.
- R8: A match by a type-00b breakpoint raises `hit_fault`. A match by any other type raises `hit_trap`. The two never assert together.
- R9: Status bits 3:0 are set for each breakpoint that matches. They stay set until a status write, which replaces the word. A match in the same cycle as a write is still recorded.
- R10: Control bit 13 arms general detect. While it is 1, a cycle with `dreg_acc` high raises `gd_exc` and sets status bit 13. While it is 0, `dreg_acc` has no effect.
- R11: Control bit 13 clears to 0 in the same cycle as any debug exception: a breakpoint match or `gd_exc`. This clearing takes priority over a control write made in the same cycle.
- R12: Control bits 8 and 9 are stored and read back but have no effect on matching. Control bits 31:16, 13 and 9:0 are writable. All other control bits read 0. Only status bits 13 and 3:0 are writable.
- R13: `hit_vec`, `hit_fault`, `hit_trap` and `gd_exc` are registered. They assert for exactly the one cycle after the access or debug-register attempt that caused them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_ext_en | input | 1 | Debugging-extensions enable; gates I/O-type breakpoints |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data |
| ctl_rdata | output | 32 | Current control word |
| bpa_we | input | 1 | Breakpoint address write strobe |
| bpa_sel | input | 2 | Breakpoint index for the address write |
| bpa_wdata | input | ADDR_W | Breakpoint address write data |
| sts_we | input | 1 | Status word write strobe |
| sts_wdata | input | 32 | Status word write data |
| sts_rdata | output | 32 | Current status word |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | ADDR_W | Lowest byte address of the access |
| acc_nb_m1 | input | 2 | Access size in bytes minus one |
| acc_kind | input | 2 | 00 fetch, 01 data read, 10 data write, 11 I/O |
| dreg_acc | input | 1 | Core attempts a debug-register access this cycle |
| hit_vec | output | NUM_BP | Breakpoints that matched the previous access |
| hit_fault | output | 1 | Previous access matched an execution breakpoint |
| hit_trap | output | 1 | Previous access matched a data or I/O breakpoint |
| gd_exc | output | 1 | General-detect exception raised |

## Verification
The hardest situation to reach is a partial overlap, where the access and the aligned breakpoint range share only an edge byte. Directed accesses therefore start just below the aligned base, with a size that reaches exactly one byte into the range. Matching accesses are paired with ones that stop one byte short. Unaligned breakpoint addresses are programmed on purpose so that the alignment masking decides the result. The self-clearing arm bit is checked in two ways. Two back-to-back debug-register attempts are issued, and the second must do nothing. A data match is also made while the bit is armed, and the bit must drop without any register access.

// File: rtl/hwbp_pkg.sv
package hwbp_pkg;

  localparam int unsigned CTL_W    = 32;
  localparam int unsigned GD_BIT   = 13;
  localparam int unsigned BD_BIT   = 13;
  localparam int unsigned FLD_BASE = 16;

  localparam logic [31:0] CTL_WMASK = 32'hFFFF_23FF;
  localparam logic [31:0] STS_WMASK = 32'h0000_200F;

  localparam logic [1:0] KIND_FETCH = 2'b00;
  localparam logic [1:0] KIND_DRD   = 2'b01;
  localparam logic [1:0] KIND_DWR   = 2'b10;
  localparam logic [1:0] KIND_IO    = 2'b11;

  localparam logic [1:0] BT_EXEC = 2'b00;
  localparam logic [1:0] BT_WR   = 2'b01;
  localparam logic [1:0] BT_IO   = 2'b10;
  localparam logic [1:0] BT_RW   = 2'b11;

  localparam logic [1:0] LEN_1   = 2'b00;
  localparam logic [1:0] LEN_2   = 2'b01;
  localparam logic [1:0] LEN_BAD = 2'b10;
  localparam logic [1:0] LEN_4   = 2'b11;

  typedef struct packed {
    logic [1:0] en;
    logic [1:0] ty;
    logic [1:0] ln;
  } bp_cfg_t;

  function automatic logic kind_match(logic [1:0] ty, logic [1:0] kind, logic de);
    logic r;
    case (ty)
      BT_EXEC: r = (kind == KIND_FETCH);
      BT_WR:   r = (kind == KIND_DWR);
      BT_IO:   r = de && (kind == KIND_IO);
      default: r = (kind == KIND_DRD) || (kind == KIND_DWR);
    endcase
    return r;
  endfunction

  function automatic logic len_legal(logic [1:0] ty, logic [1:0] ln);
    return (ln != LEN_BAD) && !((ty == BT_EXEC) && (ln != LEN_1));
  endfunction

  function automatic logic [1:0] len_span(logic [1:0] ln);
    logic [1:0] s;
    case (ln)
      LEN_2:   s = 2'd1;
      LEN_4:   s = 2'd3;
      default: s = 2'd0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/hwbp_slot.sv
module hwbp_slot
  import hwbp_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_we,
  input  logic [ADDR_W-1:0] addr_wdata,
  input  bp_cfg_t           cfg,
  input  logic              de,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_nb_m1,
  input  logic [1:0]        acc_kind,
  output logic              hit
);

  localparam int unsigned XW = ADDR_W + 1;

  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        span;
  logic [ADDR_W-1:0] amask;
  logic [XW-1:0]     rng_lo, rng_hi, acc_lo, acc_hi;
  logic              overlap;

  always_comb begin
    base_d = base_q;
    if (addr_we) base_d = addr_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= base_d;
  end

  always_comb begin
    span    = len_span(cfg.ln);
    amask   = {{(ADDR_W-2){1'b1}}, ~span};
    rng_lo  = {1'b0, base_q & amask};
    rng_hi  = rng_lo + {{(XW-2){1'b0}}, span};
    acc_lo  = {1'b0, acc_addr};
    acc_hi  = acc_lo + {{(XW-2){1'b0}}, acc_nb_m1};
    overlap = (acc_lo <= rng_hi) && (rng_lo <= acc_hi);
    hit     = acc_valid && (|cfg.en) && len_legal(cfg.ty, cfg.ln)
              && kind_match(cfg.ty, acc_kind, de) && overlap;
  end

  p_len_undef_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.ln == LEN_BAD) |-> !hit);
  p_exec_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg.ty == BT_EXEC) && (cfg.ln != LEN_1)) |-> !hit);
  p_io_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg.ty == BT_IO) && !de) |-> !hit);
  p_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.en == 2'b00) |-> !hit);

endmodule

// File: rtl/hwbp_ctrl.sv
module hwbp_ctrl
  import hwbp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  input  logic             exc_fire,
  output logic [CTL_W-1:0] ctl_q
);

  logic [CTL_W-1:0] ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (we)       ctl_d = wdata & CTL_WMASK;
    if (exc_fire) ctl_d[GD_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  p_gd_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    exc_fire |=> !ctl_q[GD_BIT]);

endmodule

// File: rtl/hwbp_status.sv
module hwbp_status
  import hwbp_pkg::*;
#(
  parameter int unsigned NUM_BP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  input  logic [NUM_BP-1:0] set_hit,
  input  logic             set_bd,
  output logic [CTL_W-1:0] sts_q
);

  logic [CTL_W-1:0] sts_d;

  always_comb begin
    sts_d = sts_q;
    if (we) sts_d = wdata & STS_WMASK;
    sts_d[NUM_BP-1:0] = sts_d[NUM_BP-1:0] | set_hit;
    if (set_bd) sts_d[BD_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= sts_d;
  end

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(we) |-> ((sts_q[NUM_BP-1:0] & $past(sts_q[NUM_BP-1:0])) == $past(sts_q[NUM_BP-1:0])));

endmodule

// File: rtl/hwbp_unit.sv
module hwbp_unit
  import hwbp_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned NUM_BP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_ext_en,
  input  logic              ctl_we,
  input  logic [31:0]       ctl_wdata,
  output logic [31:0]       ctl_rdata,
  input  logic              bpa_we,
  input  logic [1:0]        bpa_sel,
  input  logic [ADDR_W-1:0] bpa_wdata,
  input  logic              sts_we,
  input  logic [31:0]       sts_wdata,
  output logic [31:0]       sts_rdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_nb_m1,
  input  logic [1:0]        acc_kind,
  input  logic              dreg_acc,
  output logic [NUM_BP-1:0] hit_vec,
  output logic              hit_fault,
  output logic              hit_trap,
  output logic              gd_exc
);

  localparam int unsigned SEL_W = 2;

  logic [CTL_W-1:0]  ctl_q;
  logic [CTL_W-1:0]  sts_q;
  logic [NUM_BP-1:0] hit_c, exec_c;
  logic              gd_c, exc_fire, fault_c, trap_c;
  bp_cfg_t           cfg   [NUM_BP];

  logic [NUM_BP-1:0] hit_q, hit_d;
  logic              fault_q, fault_d, trap_q, trap_d, gd_q, gd_d;

  for (genvar n = 0; n < NUM_BP; n++) begin : g_slot
    assign cfg[n].en = ctl_q[2*n+1 -: 2];
    assign cfg[n].ty = ctl_q[FLD_BASE + 4*n + 1 -: 2];
    assign cfg[n].ln = ctl_q[FLD_BASE + 4*n + 3 -: 2];
    assign exec_c[n] = (cfg[n].ty == BT_EXEC);

    hwbp_slot #(.ADDR_W(ADDR_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr_we    (bpa_we && (bpa_sel == SEL_W'(n))),
      .addr_wdata (bpa_wdata),
      .cfg        (cfg[n]),
      .de         (dbg_ext_en),
      .acc_valid  (acc_valid),
      .acc_addr   (acc_addr),
      .acc_nb_m1  (acc_nb_m1),
      .acc_kind   (acc_kind),
      .hit        (hit_c[n])
    );
  end

  always_comb begin
    gd_c     = dreg_acc && ctl_q[GD_BIT];
    fault_c  = |(hit_c & exec_c);
    trap_c   = |(hit_c & ~exec_c);
    exc_fire = (|hit_c) || gd_c;
  end

  hwbp_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (ctl_we),
    .wdata    (ctl_wdata),
    .exc_fire (exc_fire),
    .ctl_q    (ctl_q)
  );

  hwbp_status #(.NUM_BP(NUM_BP)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (sts_we),
    .wdata   (sts_wdata),
    .set_hit (hit_c),
    .set_bd  (gd_c),
    .sts_q   (sts_q)
  );

  always_comb begin
    hit_d   = hit_c;
    fault_d = fault_c;
    trap_d  = trap_c;
    gd_d    = gd_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q   <= '0;
      fault_q <= 1'b0;
      trap_q  <= 1'b0;
      gd_q    <= 1'b0;
    end else begin
      hit_q   <= hit_d;
      fault_q <= fault_d;
      trap_q  <= trap_d;
      gd_q    <= gd_d;
    end
  end

  assign hit_vec   = hit_q;
  assign hit_fault = fault_q;
  assign hit_trap  = trap_q;
  assign gd_exc    = gd_q;
  assign ctl_rdata = ctl_q;
  assign sts_rdata = sts_q;

  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_fault && hit_trap));
  p_class_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_vec) |-> (hit_fault || hit_trap));
  p_gd_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((|hit_vec) || gd_exc) |-> !ctl_rdata[GD_BIT]);
  p_hit_logged_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_vec) |-> ((sts_rdata[NUM_BP-1:0] & hit_vec) == hit_vec));
  p_bd_logged_r10: assert property (@(posedge clk) disable iff (!rst_n)
    gd_exc |-> sts_rdata[BD_BIT]);
  p_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(acc_valid) |-> (hit_vec == '0));

endmodule

// File: tb/sim_hwbp_unit.sv
module sim_hwbp_unit;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dbg_ext_en = 1'b0;
  logic        ctl_we = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic [31:0] ctl_rdata;
  logic        bpa_we = 1'b0;
  logic [1:0]  bpa_sel = '0;
  logic [31:0] bpa_wdata = '0;
  logic        sts_we = 1'b0;
  logic [31:0] sts_wdata = '0;
  logic [31:0] sts_rdata;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [1:0]  acc_nb_m1 = '0;
  logic [1:0]  acc_kind = '0;
  logic        dreg_acc = 1'b0;
  logic [3:0]  hit_vec;
  logic        hit_fault, hit_trap, gd_exc;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  hwbp_unit u0 (
    .clk(clk), .rst_n(rst_n), .dbg_ext_en(dbg_ext_en),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .bpa_we(bpa_we), .bpa_sel(bpa_sel), .bpa_wdata(bpa_wdata),
    .sts_we(sts_we), .sts_wdata(sts_wdata), .sts_rdata(sts_rdata),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_nb_m1(acc_nb_m1),
    .acc_kind(acc_kind), .dreg_acc(dreg_acc),
    .hit_vec(hit_vec), .hit_fault(hit_fault), .hit_trap(hit_trap), .gd_exc(gd_exc)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cfg(int n, logic [1:0] en, logic [1:0] ty, logic [1:0] ln);
    logic [31:0] w;
    w = '0;
    w[2*n +: 2] = en;
    w[16+4*n +: 2] = ty;
    w[18+4*n +: 2] = ln;
    return w;
  endfunction

  task automatic wr_ctl(logic [31:0] d);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = d;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wr_sts(logic [31:0] d);
    @(negedge clk); sts_we = 1'b1; sts_wdata = d;
    @(negedge clk); sts_we = 1'b0;
  endtask

  task automatic wr_bpa(logic [1:0] s, logic [31:0] a);
    @(negedge clk); bpa_we = 1'b1; bpa_sel = s; bpa_wdata = a;
    @(negedge clk); bpa_we = 1'b0;
  endtask

  // one access; outputs sampled at the next falling edge
  task automatic acc(logic [31:0] a, logic [1:0] nb, logic [1:0] k);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_nb_m1 = nb; acc_kind = k;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic t_reset_r1();
    chk("R1 ctl", ctl_rdata, 32'h0);
    chk("R1 sts", sts_rdata, 32'h0);
    chk("R1 events", {hit_vec, hit_fault, hit_trap, gd_exc}, 32'h0);
  endtask

  task automatic t_length_r2();
    wr_bpa(2'd0, 32'h0000_1003);
    wr_bpa(2'd1, 32'h0000_2001);
    wr_bpa(2'd2, 32'h0000_3005);
    wr_ctl(cfg(0, 2'b01, 2'b11, 2'b11) | cfg(1, 2'b01, 2'b11, 2'b01) | cfg(2, 2'b01, 2'b11, 2'b00));
    acc(32'h1002, 2'd0, 2'b01); chk("R2 four-byte inside", {28'h0, hit_vec}, 32'h1);
    chk("R8 data trap", {30'h0, hit_fault, hit_trap}, 32'h1);
    acc(32'h1004, 2'd0, 2'b01); chk("R2 four-byte past end", {28'h0, hit_vec}, 32'h0);
    acc(32'h0FFE, 2'd3, 2'b01); chk("R2 partial overlap low", {28'h0, hit_vec}, 32'h1);
    acc(32'h0FFC, 2'd3, 2'b01); chk("R2 one byte short", {28'h0, hit_vec}, 32'h0);
    acc(32'h2002, 2'd0, 2'b10); chk("R2 two-byte past end", {28'h0, hit_vec}, 32'h0);
    acc(32'h2000, 2'd0, 2'b10); chk("R2 two-byte aligned base", {28'h0, hit_vec}, 32'h2);
    acc(32'h3004, 2'd1, 2'b01); chk("R2 one-byte overlap", {28'h0, hit_vec}, 32'h4);
    acc(32'h3006, 2'd1, 2'b01); chk("R2 one-byte miss", {28'h0, hit_vec}, 32'h0);
  endtask

  task automatic t_pulse_r13();
    acc(32'h1001, 2'd0, 2'b01);
    chk("R13 hit cycle", {28'h0, hit_vec}, 32'h1);
    @(negedge clk);
    chk("R13 single cycle", {28'h0, hit_vec, hit_trap}, 32'h0);
  endtask

  task automatic t_sticky_r9();
    wr_sts(32'h0);
    acc(32'h2001, 2'd0, 2'b01);
    acc(32'h5000, 2'd0, 2'b01);
    chk("R9 sticky after miss", sts_rdata, 32'h2);
    acc(32'h1000, 2'd0, 2'b01);
    chk("R9 accumulates", sts_rdata, 32'h3);
    wr_sts(32'hFFFF_FFF0);
    chk("R9 write replaces and masks", sts_rdata, 32'h0000_2000);
    wr_sts(32'h0);
    chk("R9 cleared", sts_rdata, 32'h0);
  endtask

  task automatic t_len_undef_r3();
    wr_bpa(2'd0, 32'h0000_1000);
    wr_ctl(cfg(0, 2'b01, 2'b11, 2'b10));
    acc(32'h1000, 2'd3, 2'b01);
    chk("R3 length 10b no hit", {28'h0, hit_vec}, 32'h0);
  endtask

  task automatic t_type_r4();
    wr_bpa(2'd1, 32'h0000_0040);
    wr_ctl(cfg(1, 2'b10, 2'b01, 2'b00));
    acc(32'h40, 2'd0, 2'b01); chk("R4 write-only ignores read", {28'h0, hit_vec}, 32'h0);
    acc(32'h40, 2'd0, 2'b10); chk("R4 write-only write", {28'h0, hit_vec}, 32'h2);
    acc(32'h40, 2'd0, 2'b11); chk("R4 write-only ignores io", {28'h0, hit_vec}, 32'h0);
    acc(32'h40, 2'd0, 2'b00); chk("R4 write-only ignores fetch", {28'h0, hit_vec}, 32'h0);
    wr_ctl(cfg(1, 2'b10, 2'b11, 2'b00));
    acc(32'h40, 2'd0, 2'b01); chk("R4 rw read", {28'h0, hit_vec}, 32'h2);
    acc(32'h40, 2'd0, 2'b11); chk("R4 rw ignores io", {28'h0, hit_vec}, 32'h0);
  endtask

  task automatic t_exec_r5_r8();
    wr_bpa(2'd3, 32'h0000_0080);
    wr_ctl(cfg(3, 2'b01, 2'b00, 2'b01));
    acc(32'h80, 2'd0, 2'b00); chk("R5 exec with length 01b", {28'h0, hit_vec}, 32'h0);
    wr_ctl(cfg(3, 2'b01, 2'b00, 2'b00));
    acc(32'h80, 2'd0, 2'b01); chk("R4 exec ignores read", {28'h0, hit_vec}, 32'h0);
    acc(32'h80, 2'd0, 2'b00); chk("R4 exec fetch", {28'h0, hit_vec}, 32'h8);
    chk("R8 exec fault", {30'h0, hit_fault, hit_trap}, 32'h2);
  endtask

  task automatic t_io_r6();
    wr_bpa(2'd2, 32'h0000_0060);
    wr_ctl(cfg(2, 2'b01, 2'b10, 2'b00));
    dbg_ext_en = 1'b0;
    acc(32'h60, 2'd0, 2'b11); chk("R6 io disabled", {28'h0, hit_vec}, 32'h0);
    dbg_ext_en = 1'b1;
    acc(32'h60, 2'd0, 2'b11); chk("R6 io enabled", {28'h0, hit_vec}, 32'h4);
    chk("R8 io trap", {30'h0, hit_fault, hit_trap}, 32'h1);
    dbg_ext_en = 1'b0;
  endtask

  task automatic t_enable_r7();
    wr_bpa(2'd2, 32'h0000_0070);
    wr_ctl(cfg(2, 2'b10, 2'b11, 2'b00));
    acc(32'h70, 2'd0, 2'b01); chk("R7 global enable only", {28'h0, hit_vec}, 32'h4);
    wr_ctl(cfg(2, 2'b00, 2'b11, 2'b00));
    acc(32'h70, 2'd0, 2'b01); chk("R7 no enable", {28'h0, hit_vec}, 32'h0);
  endtask

  task automatic t_exact_r12();
    wr_ctl(cfg(2, 2'b01, 2'b11, 2'b00) | 32'h0000_0300 | 32'h0000_0C00);
    chk("R12 readback mask", ctl_rdata, cfg(2, 2'b01, 2'b11, 2'b00) | 32'h0000_0300);
    acc(32'h70, 2'd0, 2'b01); chk("R12 exact bits no effect", {28'h0, hit_vec}, 32'h4);
  endtask

  task automatic t_gd_r10_r11();
    wr_sts(32'h0);
    @(negedge clk); dreg_acc = 1'b1;
    @(negedge clk); dreg_acc = 1'b0;
    chk("R10 disarmed ignores access", {31'h0, gd_exc}, 32'h0);
    chk("R10 disarmed no status", sts_rdata, 32'h0);
    wr_ctl(32'h0000_2000);
    chk("R10 armed", ctl_rdata, 32'h0000_2000);
    @(negedge clk); dreg_acc = 1'b1;
    @(negedge clk);
    chk("R10 gd exception", {31'h0, gd_exc}, 32'h1);
    chk("R10 status bit 13", sts_rdata, 32'h0000_2000);
    chk("R11 cleared by gd", ctl_rdata, 32'h0);
    @(negedge clk); dreg_acc = 1'b0;
    chk("R11 second attempt ignored", {31'h0, gd_exc}, 32'h0);
    wr_bpa(2'd0, 32'h0000_0090);
    wr_ctl(32'h0000_2000 | cfg(0, 2'b01, 2'b11, 2'b00));
    acc(32'h90, 2'd0, 2'b10);
    chk("R11 cleared by data hit", ctl_rdata, cfg(0, 2'b01, 2'b11, 2'b00));
    // write re-arming in the same cycle as a hit: clear wins
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = 32'h0000_2000 | cfg(0, 2'b01, 2'b11, 2'b00);
    acc_valid = 1'b1; acc_addr = 32'h90; acc_nb_m1 = 2'd0; acc_kind = 2'b01;
    @(negedge clk);
    ctl_we = 1'b0; acc_valid = 1'b0;
    chk("R11 clear beats write", {31'h0, ctl_rdata[13]}, 32'h0);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_r1();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_r1();
    t_length_r2();
    t_pulse_r13();
    t_sticky_r9();
    t_len_undef_r3();
    t_type_r4();
    t_exec_r5_r8();
    t_io_r6();
    t_enable_r7();
    t_exact_r12();
    t_gd_r10_r11();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule